// File: doc/BRIEF.md
# AHB-Lite to Peripheral Bus Bridge

This block is an AHB-Lite slave that sits in front of a row of slow, narrow register peripherals. Each peripheral owns one fixed 4 KB window of the bridge's address range. The bridge accepts one system transfer at a time. It picks the target window from the address and drives a plain select / enable / write / byte-strobe interface toward that peripheral. It keeps HREADY low until the peripheral side has finished.

Every peripheral's data port is 8, 16 or 32 bits wide, chosen per window through a static configuration input. When the system transfer is wider than the selected port, the bridge breaks it into a run of narrower peripheral cycles, lowest byte address first. It steers write bytes onto the port lanes and collects the read bytes back into their system lanes. The last window has no peripheral behind it and answers with an AHB error. Reads always cost at least two data-phase cycles and writes at least three.

Top module: `ahb_periph_bridge`

## Requirements
- R1: A transfer starts when hsel, htrans[1] and hready are all high. The window index is haddr[16:12], and during each peripheral cycle exactly one p_sel bit is high: the one at that index. When no peripheral cycle is running, p_sel is all zero.
- R2: With p_ready held high, a read to a mapped window keeps hreadyout low for N data-phase cycles and raises it in cycle N+1, where N is the number of peripheral cycles. The shortest read is therefore two cycles.
- R3: With p_ready held high, a write to a mapped window keeps hreadyout low for N+1 data-phase cycles and raises it in cycle N+2. The first of these cycles captures hwdata, and the shortest write is therefore three cycles.
- R4: Transfer size is set by hsize (0 = byte, 1 = halfword, 2 = word), and the port width is given as a log2 byte count p. The number of peripheral cycles N is 2^(hsize-p) when hsize > p, and 1 otherwise. The first p_addr equals haddr[11:0], and each following cycle adds the size of one peripheral cycle in bytes.
- R5: The port width of window s is set by slot_width_cfg[2s+1:2s]: 0 selects an 8-bit port, 1 a 16-bit port, and 2 or 3 a 32-bit port.
- R6: In each write cycle, p_be marks the port lanes starting at lane (p_addr mod port bytes), one lane per byte of that cycle. Each marked lane of p_wdata carries the hwdata byte whose system lane matches that byte's address modulo 4, and p_write is high.
- R7: On a read, each byte taken from the port lane is placed in the hrdata lane given by its address modulo 4. Lanes outside the transfer read as zero, and hrdata is valid in the cycle hreadyout returns high.
- R8: A transfer to window 31 produces no peripheral cycle. Its data phase is one cycle with hresp high and hreadyout low, followed by one cycle with hresp high and hreadyout high.
- R9: Out of reset, and after an IDLE (htrans 00) or BUSY (htrans 01) transfer, hreadyout is high and hresp is low, with no wait state and no peripheral cycle.
- R10: While p_en is high and p_ready is low, the peripheral cycle is held: p_addr and p_sel stay stable, and hreadyout stays low. Each such cycle adds one cycle to the latency.
- R11: A new transfer may be presented in the cycle where hreadyout is high. It is captured on that edge, without an idle cycle in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hsel | input | 1 | Slave select from the address decoder |
| haddr | input | ADDR_W | Transfer address |
| htrans | input | 2 | Transfer type |
| hsize | input | 3 | Transfer size |
| hwrite | input | 1 | High for a write |
| hwdata | input | DATA_W | Write data, valid in the data phase |
| hready | input | 1 | Bus-wide ready, end of previous data phase |
| hreadyout | output | 1 | This slave's ready |
| hresp | output | 1 | High for an ERROR response |
| hrdata | output | DATA_W | Read data |
| slot_width_cfg | input | 2*NUM_SLOTS | Static port width code for each window |
| p_sel | output | NUM_SLOTS | One-hot peripheral select |
| p_en | output | 1 | Peripheral cycle active |
| p_write | output | 1 | Peripheral cycle is a write |
| p_addr | output | SLOT_AW | Byte offset inside the window |
| p_be | output | DATA_W/8 | Active port byte lanes |
| p_wdata | output | DATA_W | Port write data |
| p_rdata | input | DATA_W | Port read data from the selected peripheral |
| p_ready | input | 1 | Peripheral completes the current cycle |

## Verification
The bench sweeps every legal combination of transfer size and aligned offset, across windows of all three port widths, including the code-3 alias and the highest mapped window. The peripheral returns junk on the lanes it does not own, so a bridge that reads the wrong port lane, or fails to clear the lanes outside the transfer, returns wrong hrdata. A design that counted the wrong number of split cycles, or stepped p_addr by the system size instead of the port size, would show a wrong cycle count, a wrong address, or a wrong latency. The bench also covers window 31, back-to-back transfers and peripheral stalls. A single-cycle error, a missed pipelined capture, or a beat that advances while p_ready is low would each show up as a misplaced hreadyout or hresp edge.

// File: rtl/ahbpb_pkg.sv
// Shared types and helpers for the AHB-Lite peripheral bridge.
package ahbpb_pkg;

    // Data-phase state of the bridge.
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_WLATCH = 3'd1,
        ST_ACCESS = 3'd2,
        ST_DONE   = 3'd3,
        ST_ERR1   = 3'd4,
        ST_ERR2   = 3'd5
    } br_state_e;

    // Port width code to log2 of port bytes; code 3 aliases 32 bits.
    function automatic logic [1:0] port_lg(input logic [1:0] code);
        return (code == 2'd3) ? 2'd2 : code;
    endfunction

    // Smaller of two log2 sizes.
    function automatic logic [1:0] min_lg(input logic [1:0] a, input logic [1:0] b);
        return (a < b) ? a : b;
    endfunction

endpackage

// File: rtl/ahbpb_slot_decode.sv
// Window decoder: turns a window index into a mapped flag and the
// log2 byte width of that window's port.
// Assumes: width_cfg is static while transfers are in flight.
module ahbpb_slot_decode
    import ahbpb_pkg::*;
#(
    parameter int NUM_SLOTS = 31,
    parameter int IDX_W     = 5
) (
    input  logic [IDX_W-1:0]       slot_idx,
    input  logic [2*NUM_SLOTS-1:0] width_cfg,
    output logic                   mapped,
    output logic [1:0]             plg
);

    logic [1:0] cfg_lg [NUM_SLOTS];

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_cfg
        assign cfg_lg[g] = port_lg(width_cfg[2*g +: 2]);
    end

    // Select the width of the addressed window; unmapped reads as 8-bit.
    always_comb begin
        plg = 2'd0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (slot_idx == IDX_W'(i)) plg = cfg_lg[i];
        end
    end

    // Index at or beyond NUM_SLOTS has no peripheral.
    assign mapped = (32'(slot_idx) < NUM_SLOTS);

endmodule

// File: rtl/ahbpb_lanes.sv
// Byte lane steering between the system data bus and a narrow port.
// Assumes: the current beat address is aligned to the beat size, and
// the beat never crosses the port width.
module ahbpb_lanes #(
    parameter int BYTES = 4,
    parameter int LW    = 2
) (
    input  logic [LW-1:0]        lo,
    input  logic [1:0]           blg,
    input  logic [1:0]           plg,
    input  logic [8*BYTES-1:0]   wdata,
    input  logic [8*BYTES-1:0]   prdata,
    input  logic [8*BYTES-1:0]   rdata_q,
    output logic [8*BYTES-1:0]   pwdata,
    output logic [BYTES-1:0]     pbe,
    output logic [8*BYTES-1:0]   rdata_nx
);

    // Map beat bytes onto port lanes and merge port bytes into system lanes.
    always_comb begin
        int a0;
        int plane;
        int nb;
        a0       = int'(lo);
        plane    = a0 & ((1 << plg) - 1);
        nb       = 1 << blg;
        pbe      = '0;
        pwdata   = '0;
        rdata_nx = rdata_q;
        for (int pl = 0; pl < BYTES; pl++) begin
            if (pl >= plane && pl < plane + nb) begin
                pbe[pl]           = 1'b1;
                pwdata[8*pl +: 8] = wdata[8*(pl - plane + a0) +: 8];
            end
        end
        for (int l = 0; l < BYTES; l++) begin
            if (l >= a0 && l < a0 + nb) begin
                rdata_nx[8*l +: 8] = prdata[8*(l - a0 + plane) +: 8];
            end
        end
    end

endmodule

// File: rtl/ahbpb_ctrl.sv
// Transfer sequencer: captures the address phase, counts peripheral
// beats, advances the beat address and drives the AHB response.
// Assumes: only one transfer in flight; hready follows hreadyout when
// this slave owns the data phase.
module ahbpb_ctrl
    import ahbpb_pkg::*;
#(
    parameter int OFF_W = 12,
    parameter int IDX_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic             req_wr,
    input  logic [1:0]       req_sz,
    input  logic [OFF_W-1:0] req_off,
    input  logic [IDX_W-1:0] req_idx,
    input  logic             req_mapped,
    input  logic [1:0]       req_plg,
    input  logic             p_ready,
    output br_state_e        state_q,
    output logic             accept,
    output logic             hreadyout,
    output logic             hresp,
    output logic             wr_q,
    output logic [1:0]       plg_q,
    output logic [1:0]       blg_q,
    output logic [OFF_W-1:0] off_q,
    output logic [IDX_W-1:0] idx_q,
    output logic             beat_done
);

    logic [1:0] left_q;
    logic [1:0] req_blg;
    logic [1:0] req_left;

    // Beat size and extra beats for the incoming transfer.
    always_comb begin
        req_blg = min_lg(req_sz, req_plg);
        unique case (2'(req_sz - req_blg))
            2'd0:    req_left = 2'd0;
            2'd1:    req_left = 2'd1;
            default: req_left = 2'd3;
        endcase
    end

    assign hreadyout = (state_q == ST_IDLE) || (state_q == ST_DONE) || (state_q == ST_ERR2);
    assign hresp     = (state_q == ST_ERR1) || (state_q == ST_ERR2);
    assign accept    = req && hreadyout;
    assign beat_done = (state_q == ST_ACCESS) && p_ready;

    // State, transfer attributes and beat address sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            wr_q    <= 1'b0;
            plg_q   <= 2'd0;
            blg_q   <= 2'd0;
            off_q   <= '0;
            idx_q   <= '0;
            left_q  <= 2'd0;
        end else begin
            case (state_q)
                ST_IDLE, ST_DONE, ST_ERR2: begin
                    if (accept) begin
                        wr_q   <= req_wr;
                        plg_q  <= req_plg;
                        blg_q  <= req_blg;
                        off_q  <= req_off;
                        idx_q  <= req_idx;
                        left_q <= req_left;
                        if (!req_mapped)  state_q <= ST_ERR1;
                        else if (req_wr)  state_q <= ST_WLATCH;
                        else              state_q <= ST_ACCESS;
                    end else begin
                        state_q <= ST_IDLE;
                    end
                end
                ST_WLATCH: state_q <= ST_ACCESS;
                ST_ACCESS: begin
                    if (p_ready) begin
                        if (left_q == 2'd0) begin
                            state_q <= ST_DONE;
                        end else begin
                            left_q <= left_q - 2'd1;
                            off_q  <= off_q + (OFF_W'(1) << blg_q);
                        end
                    end
                end
                ST_ERR1: state_q <= ST_ERR2;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R2: a mapped read inserts at least one wait state.
    a_r2_read_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && req_mapped && !req_wr) |=> !hreadyout);

    // R3: a mapped write inserts at least two wait states.
    a_r3_write_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && req_mapped && req_wr) |=> !hreadyout ##1 !hreadyout);

    // R8: the error response spans exactly two cycles.
    a_r8_err_two_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (hresp && !hreadyout) |=> (hresp && hreadyout));

    // R8: an unmapped window goes straight to the error response.
    a_r8_err_start: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !req_mapped) |=> (hresp && !hreadyout));

endmodule

// File: rtl/ahb_periph_bridge.sv
// AHB-Lite slave bridging to narrow windowed peripherals. It decodes
// the window, splits wide transfers into port-sized beats, steers
// byte lanes and holds hreadyout low until the last beat is done.
// Assumes: transfers are naturally aligned, no bursts are optimised,
// and slot_width_cfg is static.
module ahb_periph_bridge
    import ahbpb_pkg::*;
#(
    parameter int NUM_SLOTS = 31,
    parameter int SLOT_AW   = 12,
    parameter int ADDR_W    = 32,
    parameter int DATA_W    = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   hsel,
    input  logic [ADDR_W-1:0]      haddr,
    input  logic [1:0]             htrans,
    input  logic [2:0]             hsize,
    input  logic                   hwrite,
    input  logic [DATA_W-1:0]      hwdata,
    input  logic                   hready,
    output logic                   hreadyout,
    output logic                   hresp,
    output logic [DATA_W-1:0]      hrdata,
    input  logic [2*NUM_SLOTS-1:0] slot_width_cfg,
    output logic [NUM_SLOTS-1:0]   p_sel,
    output logic                   p_en,
    output logic                   p_write,
    output logic [SLOT_AW-1:0]     p_addr,
    output logic [DATA_W/8-1:0]    p_be,
    output logic [DATA_W-1:0]      p_wdata,
    input  logic [DATA_W-1:0]      p_rdata,
    input  logic                   p_ready
);

    localparam int BYTES = DATA_W / 8;
    localparam int LW    = $clog2(BYTES);
    localparam int IDX_W = $clog2(NUM_SLOTS + 1);

    br_state_e          state_q;
    logic               req;
    logic [1:0]         req_sz;
    logic [IDX_W-1:0]   req_idx;
    logic               req_mapped;
    logic [1:0]         req_plg;
    logic               accept;
    logic               wr_q;
    logic [1:0]         plg_q;
    logic [1:0]         blg_q;
    logic [SLOT_AW-1:0] off_q;
    logic [IDX_W-1:0]   idx_q;
    logic               beat_done;
    logic [DATA_W-1:0]  wdata_q;
    logic [DATA_W-1:0]  rdata_q;
    logic [DATA_W-1:0]  rdata_nx;
    logic [DATA_W-1:0]  lane_wdata;
    logic [BYTES-1:0]   lane_be;
    logic               unused_bits;

    assign unused_bits = ^{haddr[ADDR_W-1:SLOT_AW+IDX_W], htrans[0]};

    assign req     = hsel && htrans[1] && hready;
    assign req_sz  = (hsize > 3'd2) ? 2'd2 : hsize[1:0];
    assign req_idx = haddr[SLOT_AW +: IDX_W];

    ahbpb_slot_decode #(
        .NUM_SLOTS(NUM_SLOTS),
        .IDX_W    (IDX_W)
    ) u_decode (
        .slot_idx (req_idx),
        .width_cfg(slot_width_cfg),
        .mapped   (req_mapped),
        .plg      (req_plg)
    );

    ahbpb_ctrl #(
        .OFF_W(SLOT_AW),
        .IDX_W(IDX_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (req),
        .req_wr    (hwrite),
        .req_sz    (req_sz),
        .req_off   (haddr[SLOT_AW-1:0]),
        .req_idx   (req_idx),
        .req_mapped(req_mapped),
        .req_plg   (req_plg),
        .p_ready   (p_ready),
        .state_q   (state_q),
        .accept    (accept),
        .hreadyout (hreadyout),
        .hresp     (hresp),
        .wr_q      (wr_q),
        .plg_q     (plg_q),
        .blg_q     (blg_q),
        .off_q     (off_q),
        .idx_q     (idx_q),
        .beat_done (beat_done)
    );

    ahbpb_lanes #(
        .BYTES(BYTES),
        .LW   (LW)
    ) u_lanes (
        .lo      (off_q[LW-1:0]),
        .blg     (blg_q),
        .plg     (plg_q),
        .wdata   (wdata_q),
        .prdata  (p_rdata),
        .rdata_q (rdata_q),
        .pwdata  (lane_wdata),
        .pbe     (lane_be),
        .rdata_nx(rdata_nx)
    );

    // Hold the write data captured in the first write data-phase cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)                    wdata_q <= '0;
        else if (state_q == ST_WLATCH) wdata_q <= hwdata;
    end

    // Clear read assembly on a new transfer; merge each finished read beat.
    always_ff @(posedge clk) begin
        if (!rst_n)                     rdata_q <= '0;
        else if (accept)                rdata_q <= '0;
        else if (beat_done && !wr_q)    rdata_q <= rdata_nx;
    end

    assign hrdata  = rdata_q;
    assign p_en    = (state_q == ST_ACCESS);
    assign p_write = p_en && wr_q;
    assign p_addr  = off_q;
    assign p_be    = p_en ? lane_be : '0;
    assign p_wdata = p_write ? lane_wdata : '0;

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_sel
        assign p_sel[g] = p_en && (idx_q == IDX_W'(g));
    end

    // R1: one window selected during a peripheral cycle.
    a_r1_sel_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        p_en |-> ($countones(p_sel) == 1));

    // R1: no window selected outside a peripheral cycle.
    a_r1_sel_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !p_en |-> (p_sel == '0));

    // R6: active lanes match the beat size.
    a_r6_be_count: assert property (@(posedge clk) disable iff (!rst_n)
        p_en |-> ($countones(p_be) == (1 << blg_q)));

    // R9: IDLE or BUSY while ready gives a zero-wait OKAY.
    a_r9_idle_okay: assert property (@(posedge clk) disable iff (!rst_n)
        (hsel && !htrans[1] && hready && hreadyout) |=> (hreadyout && !hresp && !p_en));

    // R10: a stalled peripheral cycle holds address and select.
    a_r10_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (p_en && !p_ready) |=> (p_en && $stable(p_addr) && $stable(p_sel) && !hreadyout));

endmodule

// File: tb/ahb_periph_bridge_tb.sv
// Self-checking bench: sweeps sizes, offsets and port widths, plus the
// error window, IDLE/BUSY, back-to-back and stall cases.
module ahb_periph_bridge_tb;

    localparam int NS = 31;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hsel = 1'b0;
    logic [31:0] haddr = '0;
    logic [1:0]  htrans = 2'b00;
    logic [2:0]  hsize = 3'd0;
    logic        hwrite = 1'b0;
    logic [31:0] hwdata = '0;
    logic        hready;
    logic        hreadyout;
    logic        hresp;
    logic [31:0] hrdata;
    logic [2*NS-1:0] cfg;
    logic [NS-1:0]   p_sel;
    logic        p_en;
    logic        p_write;
    logic [11:0] p_addr;
    logic [3:0]  p_be;
    logic [31:0] p_wdata;
    logic [31:0] p_rdata;
    logic        p_ready;
    logic        stall_mode = 1'b0;
    logic        tog = 1'b0;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    int mon_on = 0;
    int mon_slot, mon_sz, mon_wr, mon_base, mon_exp_addr;
    int mon_beats, mon_stalls, mon_stray;
    logic [7:0] img [4];
    bit imgv [4];

    always #5 clk = ~clk;
    assign hready  = hreadyout;
    assign p_ready = !stall_mode || tog;

    always @(posedge clk) begin
        #1;
        tog = ~tog;
    end

    ahb_periph_bridge u_dut (
        .clk(clk), .rst_n(rst_n), .hsel(hsel), .haddr(haddr), .htrans(htrans),
        .hsize(hsize), .hwrite(hwrite), .hwdata(hwdata), .hready(hready),
        .hreadyout(hreadyout), .hresp(hresp), .hrdata(hrdata),
        .slot_width_cfg(cfg), .p_sel(p_sel), .p_en(p_en), .p_write(p_write),
        .p_addr(p_addr), .p_be(p_be), .p_wdata(p_wdata), .p_rdata(p_rdata),
        .p_ready(p_ready)
    );

    function automatic int wlg(input int s);
        int c;
        c = s % 4;
        return (c == 3) ? 2 : c;
    endfunction

    function automatic logic [7:0] pat(input int s, input int b);
        return 8'((s * 37 + b * 7 + 90) & 255);
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Peripheral model: each lane returns a pattern of its byte address.
    always_comb begin
        int s;
        int base;
        s = 0;
        for (int i = 0; i < NS; i++) if (p_sel[i]) s = i;
        base = int'(p_addr) & ~((1 << wlg(s)) - 1);
        for (int pl = 0; pl < 4; pl++) p_rdata[8*pl +: 8] = pat(s, base + pl);
    end

    // Beat monitor, sampled between edges.
    always @(negedge clk) begin
        if (mon_on != 0 && p_en) begin
            if (!p_ready) begin
                mon_stalls++;
            end else begin
                int lg;
                int bl;
                int nb;
                int plane;
                logic [3:0] ebe;
                lg = wlg(mon_slot);
                bl = (mon_sz < lg) ? mon_sz : lg;
                nb = 1 << bl;
                plane = int'(p_addr) & ((1 << lg) - 1);
                ebe = 4'(((1 << nb) - 1) << plane);
                chk(32'(p_sel) == (32'd1 << mon_slot), "R1", "window select",
                    32'(p_sel), 32'd1 << mon_slot);
                chk(int'(p_addr) == mon_exp_addr, "R4", "beat address",
                    32'(p_addr), 32'(mon_exp_addr));
                chk(p_write == (mon_wr != 0), "R6", "write flag",
                    32'(p_write), 32'(mon_wr));
                chk(p_be == ebe, "R6", "byte enables", 32'(p_be), 32'(ebe));
                if (mon_wr != 0) begin
                    for (int pl = 0; pl < 4; pl++) begin
                        if (ebe[pl]) begin
                            int k;
                            k = int'(p_addr) - plane + pl - mon_base;
                            if (k >= 0 && k < 4) begin
                                img[k]  = p_wdata[8*pl +: 8];
                                imgv[k] = 1;
                            end else begin
                                mon_stray++;
                            end
                        end
                    end
                end
                mon_exp_addr = mon_exp_addr + nb;
                mon_beats++;
            end
        end
    end

    task automatic mon_arm(input int slot, input int off, input int sz, input int wr);
        mon_slot = slot; mon_sz = sz; mon_wr = wr; mon_base = off;
        mon_exp_addr = off; mon_beats = 0; mon_stalls = 0; mon_stray = 0;
        for (int k = 0; k < 4; k++) begin img[k] = 8'h00; imgv[k] = 0; end
        mon_on = 1;
    endtask

    // One full transfer with latency, beat and data checks.
    task automatic xfer(input int slot, input int off, input int sz, input int wr,
                        input logic [31:0] wd);
        int lg, bl, beats, lat, a0, nb, exp_lat;
        logic [31:0] exp_rd;
        lg = wlg(slot);
        bl = (sz < lg) ? sz : lg;
        beats = 1 << (sz - bl);
        a0 = off & 3;
        nb = 1 << sz;
        mon_arm(slot, off, sz, wr);
        @(posedge clk); #1;
        hsel = 1; htrans = 2'b10; haddr = (32'(slot) << 12) | 32'(off);
        hsize = 3'(sz); hwrite = (wr != 0);
        @(posedge clk); #1;
        hsel = 0; htrans = 2'b00; hwdata = wd;
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
        end while (!hreadyout && lat < 100);
        exp_lat = beats + ((wr != 0) ? 2 : 1) + mon_stalls;
        chk(lat == exp_lat, (wr != 0) ? "R3" : "R2", "data-phase latency",
            32'(lat), 32'(exp_lat));
        chk(!hresp, "R2", "okay response", 32'(hresp), 32'd0);
        chk(mon_beats == beats, "R4/R5", "peripheral cycles", 32'(mon_beats), 32'(beats));
        if (wr != 0) begin
            chk(mon_stray == 0, "R6", "bytes outside transfer", 32'(mon_stray), 32'd0);
            for (int k = 0; k < 4; k++) begin
                if (k < nb)
                    chk(imgv[k] && img[k] == wd[8*(a0+k) +: 8], "R6", "written byte",
                        {23'd0, imgv[k], img[k]}, {24'd1, wd[8*(a0+k) +: 8]});
                else
                    chk(!imgv[k], "R6", "extra byte written", 32'(imgv[k]), 32'd0);
            end
        end else begin
            exp_rd = '0;
            for (int l = a0; l < a0 + nb; l++) exp_rd[8*l +: 8] = pat(slot, (off & ~3) + l);
            chk(hrdata == exp_rd, "R7", "read data", hrdata, exp_rd);
        end
        mon_on = 0;
    endtask

    // Window 31: two-cycle error, no peripheral cycle.
    task automatic err_xfer(input int wr);
        mon_arm(31, 0, 2, wr);
        @(posedge clk); #1;
        hsel = 1; htrans = 2'b10; haddr = 32'(31) << 12; hsize = 3'd2; hwrite = (wr != 0);
        @(posedge clk); #1;
        hsel = 0; htrans = 2'b00;
        @(negedge clk);
        chk(!hreadyout && hresp, "R8", "error first cycle", {30'd0, hreadyout, hresp}, 32'd1);
        @(negedge clk);
        chk(hreadyout && hresp, "R8", "error second cycle", {30'd0, hreadyout, hresp}, 32'd3);
        @(negedge clk);
        chk(hreadyout && !hresp, "R8", "back to okay", {30'd0, hreadyout, hresp}, 32'd2);
        chk(mon_beats == 0 && mon_stalls == 0, "R8", "no peripheral cycle",
            32'(mon_beats), 32'd0);
        mon_on = 0;
    endtask

    function automatic logic [31:0] word_pat(input int s, input int off);
        logic [31:0] w;
        for (int l = 0; l < 4; l++) w[8*l +: 8] = pat(s, (off & ~3) + l);
        return w;
    endfunction

    initial begin
        for (int s = 0; s < NS; s++) cfg[2*s +: 2] = 2'(s % 4);
        repeat (4) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        // R9: reset state
        chk(hreadyout && !hresp, "R9", "reset response", {30'd0, hreadyout, hresp}, 32'd2);
        chk(!p_en && p_sel == '0, "R1", "reset no select", 32'(p_sel), 32'd0);
        chk(hrdata == '0, "R7", "reset read data", hrdata, 32'd0);

        // R9: IDLE and BUSY transfers
        for (int t = 0; t < 2; t++) begin
            @(posedge clk); #1;
            hsel = 1; htrans = 2'(t); haddr = 32'h0000_2004; hsize = 3'd2; hwrite = 0;
            @(posedge clk); #1;
            hsel = 0; htrans = 2'b00;
            @(negedge clk);
            chk(hreadyout && !hresp && !p_en, "R9", "idle/busy okay",
                {29'd0, hreadyout, hresp, p_en}, 32'd4);
        end

        // Sweep of windows, sizes, offsets and directions (R1..R7)
        for (int si = 0; si < 9; si++) begin
            int slot;
            slot = (si == 8) ? 30 : si;
            for (int sz = 0; sz < 3; sz++) begin
                for (int lane = 0; lane < 4; lane += (1 << sz)) begin
                    int off;
                    off = ((slot * 12'h111) & 12'hFFC) | lane;
                    for (int wr = 0; wr < 2; wr++) begin
                        xfer(slot, off, sz, wr,
                             {8'(slot + 1), 8'(off), 8'(sz * 17 + wr), 8'hC3});
                    end
                end
            end
        end

        // R8: unmapped window
        err_xfer(0);
        err_xfer(1);

        // R11: back-to-back reads to two 32-bit windows
        @(posedge clk); #1;
        hsel = 1; htrans = 2'b10; haddr = 32'h0000_2048; hsize = 3'd2; hwrite = 0;
        @(posedge clk); #1;
        hsel = 0; htrans = 2'b00;
        @(negedge clk);
        chk(!hreadyout, "R11", "first wait", 32'(hreadyout), 32'd0);
        @(posedge clk); #1;
        hsel = 1; htrans = 2'b10; haddr = 32'h0000_60A4; hsize = 3'd2; hwrite = 0;
        @(negedge clk);
        chk(hreadyout && hrdata == word_pat(2, 12'h048), "R11", "first read data",
            hrdata, word_pat(2, 12'h048));
        @(posedge clk); #1;
        hsel = 0; htrans = 2'b00;
        @(negedge clk);
        chk(!hreadyout, "R11", "second captured", 32'(hreadyout), 32'd0);
        @(negedge clk);
        chk(hreadyout && hrdata == word_pat(6, 12'h0A4), "R11", "second read data",
            hrdata, word_pat(6, 12'h0A4));

        // R10: stalled peripheral
        @(posedge clk); #1;
        stall_mode = 1;
        xfer(0, 12'h3A0, 2, 0, 32'h0);
        chk(mon_stalls > 0, "R10", "stall cycles seen", 32'(mon_stalls), 32'd1);
        xfer(1, 12'h114, 2, 1, 32'hA1B2_C3D4);
        chk(mon_stalls > 0, "R10", "stall cycles seen", 32'(mon_stalls), 32'd1);
        @(posedge clk); #1;
        stall_mode = 0;

        repeat (2) @(posedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule